// File: doc/BRIEF.md
# Valley Skip Counter

This block sets how many ringing valleys of a quasi-resonant flyback converter are passed over before the power switch turns on again. It keeps a small unsigned count that rises when the regulation loop reports a light load and falls when the loop reports a heavy load. The switching frequency therefore steps down in small increments as the load drops, and steps back up as the load grows.

Three comparator flags describe the feedback level: below the lower band edge (light), above the upper band edge (heavy), and above a surge level (sudden load step). Light and heavy are not acted on at once. Each one sets its own sticky flag, and the count moves by at most one step on each slow sampling strobe, which has a period of about 50 ms in the target system. A surge bypasses the strobe and returns the count to one on the next clock edge, so full power is available at once. A restart input, raised at the start of soft start, puts the block back into its initial state.

Top module: `valley_skip_ctrl`

## Requirements
- R1: After reset, skip_o reads 1 (binary 0001) and both sticky flags are clear.
- R2: If below_lo_i was high in any cycle of a sampling period, and above_hi_i was not, the tick_i edge that closes the period raises skip_o by one.
- R3: If above_hi_i was high in any cycle of a sampling period, the closing tick_i edge lowers skip_o by one.
- R4: skip_o changes only on a tick_i edge, a surge or a restart. On a tick with neither flag set, it holds.
- R5: On the clock edge that samples above_rst_i high, skip_o becomes 1, whether or not tick_i is high.
- R6: An increase at 15 (binary 1111) leaves skip_o at 15.
- R7: A decrease at 1 leaves skip_o at 1. skip_o is never 0.
- R8: If both flags were set in one period, the tick decreases the count, and the light flag is ignored.
- R9: Each flag acts at most once per period. Any number of pulses in a period gives one step, and the flags are cleared by the tick.
- R10: On the clock edge that samples restart_i high, skip_o becomes 1 and both flags are cleared, so a pending condition is dropped.
- R11: A light or heavy input seen in the same cycle as tick_i does not affect that tick. It is stored for the period that follows.
- R12: A surge takes priority over a tick in the same cycle. The count goes to 1, and pending flags still clear at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Soft-start begin: synchronous return to initial state |
| tick_i | input | 1 | One-cycle sampling strobe closing a period |
| below_lo_i | input | 1 | Feedback under the lower band edge (light load) |
| above_hi_i | input | 1 | Feedback over the upper band edge (heavy load) |
| above_rst_i | input | 1 | Feedback over the surge level |
| skip_o | output | CNT_W (4) | Number of valleys to skip, unsigned |

## Verification
A corrupted count shows on skip_o at once, because the output is the count register itself. A lost or stuck sticky flag is not visible until the next tick, where it appears as a missing, extra or wrong-direction step. For that reason every scenario ends with a tick followed by a check. A flag that fails to clear would show at the following idle tick as an extra step, so the bench places idle ticks after each load phase, and after a restart, to expose it.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2,
        ACT_ONE  = 2'd3
    } vsc_act_e;

    localparam int unsigned FLAG_LIGHT = 0;
    localparam int unsigned FLAG_HEAVY = 1;
    localparam int unsigned NUM_FLAGS  = 2;

endpackage

// File: rtl/vsc_region_latch.sv
module vsc_region_latch #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    input  logic         tick_i,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] seen_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic seen_d, seen_q;

        always_comb begin
            if (restart_i)
                seen_d = 1'b0;
            else if (tick_i)
                seen_d = raw_i[g];          // new period starts with this cycle's sample
            else
                seen_d = seen_q | raw_i[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                seen_q <= 1'b0;
            else
                seen_q <= seen_d;
        end

        assign seen_o[g] = seen_q;
    end

endmodule

// File: rtl/vsc_action_dec.sv
module vsc_action_dec
    import vsc_pkg::*;
(
    input  logic                 restart_i,
    input  logic                 surge_i,
    input  logic                 tick_i,
    input  logic [NUM_FLAGS-1:0] seen_i,
    output vsc_act_e             act_o
);

    always_comb begin
        act_o = ACT_HOLD;
        if (restart_i || surge_i)
            act_o = ACT_ONE;
        else if (tick_i) begin
            if (seen_i[FLAG_HEAVY])
                act_o = ACT_DOWN;
            else if (seen_i[FLAG_LIGHT])
                act_o = ACT_UP;
        end
    end

endmodule

// File: rtl/vsc_skip_counter.sv
module vsc_skip_counter
    import vsc_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vsc_act_e         act_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MIN = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act_i)
            ACT_ONE:  st_d.cnt = CNT_MIN;
            ACT_UP:   if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            ACT_DOWN: if (st_q.cnt != CNT_MIN) st_d.cnt = st_q.cnt - 1'b1;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{cnt: CNT_MIN};
        else
            st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/valley_skip_ctrl.sv
module valley_skip_ctrl
    import vsc_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic             below_lo_i,
    input  logic             above_hi_i,
    input  logic             above_rst_i,
    output logic [CNT_W-1:0] skip_o
);

    logic [NUM_FLAGS-1:0] raw_w;
    logic [NUM_FLAGS-1:0] seen_w;
    vsc_act_e             act_w;

    always_comb begin
        raw_w             = '0;
        raw_w[FLAG_LIGHT] = below_lo_i;
        raw_w[FLAG_HEAVY] = above_hi_i;
    end

    vsc_region_latch #(.N(NUM_FLAGS)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .tick_i    (tick_i),
        .raw_i     (raw_w),
        .seen_o    (seen_w)
    );

    vsc_action_dec u_dec (
        .restart_i (restart_i),
        .surge_i   (above_rst_i),
        .tick_i    (tick_i),
        .seen_i    (seen_w),
        .act_o     (act_w)
    );

    vsc_skip_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act_w),
        .cnt_o (skip_o)
    );

endmodule

// File: rtl/vsc_checker.sv
module vsc_checker #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart_i,
    input logic             tick_i,
    input logic             surge_i,
    input logic             heavy_seen,
    input logic [CNT_W-1:0] skip
);

    a_r7_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        skip != '0);

    a_r5_surge_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        surge_i |=> skip == CNT_W'(1));

    a_r10_restart_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> skip == CNT_W'(1));

    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !surge_i && !restart_i) |=> $stable(skip));

    a_r8_heavy_never_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && heavy_seen && !surge_i && !restart_i) |=> skip <= $past(skip));

    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!surge_i && !restart_i) |=>
            (skip == $past(skip)) || (skip == $past(skip) + 1'b1) || (skip == $past(skip) - 1'b1));

endmodule

bind valley_skip_ctrl vsc_checker #(.CNT_W(CNT_W)) u_vsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart_i),
    .tick_i     (tick_i),
    .surge_i    (above_rst_i),
    .heavy_seen (seen_w[1]),
    .skip       (skip_o)
);

// File: tb/valley_skip_ctrl_bench.sv
module valley_skip_ctrl_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         restart_i = 1'b0, tick_i = 1'b0;
    logic         below_lo_i = 1'b0, above_hi_i = 1'b0, above_rst_i = 1'b0;
    logic [W-1:0] skip_o;

    int vectors = 0;
    int misses  = 0;

    // reference state, built from the requirements
    int m_cnt = 1;
    bit m_light = 0, m_heavy = 0;

    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    valley_skip_ctrl #(.CNT_W(W)) u_valley_skip_ctrl (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .tick_i(tick_i),
        .below_lo_i(below_lo_i), .above_hi_i(above_hi_i),
        .above_rst_i(above_rst_i), .skip_o(skip_o)
    );

    task automatic compare(input int exp, input string tag);
        vectors++;
        if (int'(skip_o) != exp) begin
            misses++;
            $display("FAIL %s: skip_o=%0d expected %0d", tag, skip_o, exp);
        end
    endtask

    // driver: one clock cycle of stimulus, expected result queued
    task automatic step(input bit lo, input bit hi, input bit sg, input bit tk,
                        input bit rs, input string tag);
        @(negedge clk);
        below_lo_i = lo; above_hi_i = hi; above_rst_i = sg;
        tick_i = tk; restart_i = rs;
        @(posedge clk);
        #1;
        if (rs) begin
            m_cnt = 1; m_light = 0; m_heavy = 0;
        end else begin
            if (sg) m_cnt = 1;
            else if (tk) begin
                if (m_heavy) begin if (m_cnt > 1) m_cnt--; end
                else if (m_light) begin if (m_cnt < 15) m_cnt++; end
            end
            if (tk) begin m_light = lo; m_heavy = hi; end
            else begin m_light = m_light | lo; m_heavy = m_heavy | hi; end
        end
        exp_q.push_back(m_cnt);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #(200000 * 10);
        misses++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare(1, "R1 reset value");
        step(0, 0, 0, 1, 0, "R1 idle tick after reset");

        // R2 single light pulse then tick
        step(1, 0, 0, 0, 0, "R2");
        idle(3, "R2");
        step(0, 0, 0, 1, 0, "R2 light step up");
        // R9 many pulses -> one step; then idle tick holds
        step(1, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 1, 0, "R9 one step per period");
        step(0, 0, 0, 1, 0, "R9 flags cleared by tick");
        idle(2, "R4");
        step(0, 0, 0, 1, 0, "R4 hold mid band");
        // R3 heavy
        step(0, 1, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 0, "R3 heavy step down");
        // R8 both
        step(1, 0, 0, 0, 0, "R8");
        step(0, 1, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 0, "R8 heavy wins");
        // R7 floor
        step(0, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 0, "R7 floor at one");
        // R11 input on tick cycle goes to next period
        step(1, 0, 0, 1, 0, "R11 tick-cycle light not used");
        step(0, 0, 0, 1, 0, "R11 applied next tick");
        // R6 climb to ceiling
        for (int i = 0; i < 16; i++) begin
            step(1, 0, 0, 0, 0, "R6");
            step(0, 0, 0, 1, 0, "R6 climb");
        end
        step(1, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 1, 0, "R6 ceiling at fifteen");
        // R5 surge without tick
        step(0, 0, 1, 0, 0, "R5 surge jump");
        idle(2, "R5");
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0, 0, 0, "R2");
            step(0, 0, 0, 1, 0, "R2 rebuild");
        end
        // R12 surge with tick and pending light
        step(1, 0, 0, 0, 0, "R12");
        step(0, 0, 1, 1, 0, "R12 surge beats tick");
        step(0, 0, 0, 1, 0, "R12 flags cleared");
        // R10 restart drops pending flag
        for (int i = 0; i < 2; i++) begin
            step(1, 0, 0, 0, 0, "R10");
            step(0, 0, 0, 1, 0, "R10 setup");
        end
        step(1, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 1, "R10 restart to one");
        step(0, 0, 0, 1, 0, "R10 pending light dropped");
        idle(2, "R4");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule